// File: doc/BRIEF.md
# Capture/Compare Free-Running Timer

A 16-bit timer that sits on the byte-wide register port of a small 8-bit controller. A free-running, read-only count advances once for every four core clocks. Two capture channels record the count when their pin shows the chosen edge. Two compare channels flag the moment the count reaches a programmed value and can drive a pin level at that moment. Overflow, capture and compare events each set a status flag, and each flag can raise the shared interrupt line.

Software reads the 16-bit count one byte at a time. Reading the high byte freezes the low byte in a buffer, so the pair read back is coherent. Software clears a flag in two steps. First it reads the status register while the flag is set. Then it accesses the register tied to that flag. A second view of the count is provided that never takes part in clearing the overflow flag. While the stop input is high, the count is held.

The register port has no data flow that could be held back, so it uses plain single-cycle strobes with no handshake. A read strobe presents data combinationally in the same cycle. Its side effects, such as buffering the low byte or clearing a flag, take place at the clock edge that ends the cycle.

Top module: `ctm_timer`

## Requirements
- R1: On reset the count is 16'hFFFC. Every flag, enable, edge select, level bit and compare pin is 0. Compares stay inhibited until a low compare byte has been written.
- R2: The count rises by exactly one every fourth clock and cannot be written. While stop_in is high, both the prescaler and the count hold their values.
- R3: A read of address 3 or 5 (high byte) copies the live low byte into a shared buffer, but only if the buffer is not already holding a value. A read of address 4 or 6 (low byte) returns the buffer if it is holding, and then releases it. Further high-byte reads leave a held buffer unchanged.
- R4: Capture channel i (control A bit 5+i: 1 selects the rising edge, 0 the falling edge) loads the count present before the clock edge at which the edge is seen. It also sets status bit 1+i. An edge of the other polarity changes nothing. Captures are read at addresses 7/8 (channel 0, high/low) and 9/10 (channel 1).
- R5: When the count advances onto compare value i, status bit 3+i is set. If control B bit i (output enable) is 1, the compare pin takes control B bit 2+i. If that bit is 0, the pin keeps its level.
- R6: A count step from 16'hFFFF to 16'h0000 sets status bit 0.
- R7: A flag clears only after a status read (address 2) made while the flag is set, followed by the matching access. For overflow, the matching access is a read of address 4. For a capture flag, it is a read of that channel's low capture byte. For a compare flag, it is a write of that channel's low compare byte. The same access without the earlier status read leaves the flag set.
- R8: Addresses 5/6 return the live count, like addresses 3/4, but reading them never clears the overflow flag.
- R9: A write to a compare high byte (address 11 or 13) blocks that channel's matches until its low byte (address 12 or 14) is written.
- R10: irq is high exactly when some status bit k is set and control A bit k is 1, for k = 0..4.
- R11: Control A is at address 0, 7 bits wide. Control B is at address 1, 4 bits wide. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| cap_pin | input | 2 | Capture inputs, one per channel |
| cmp_pin | output | 2 | Compare outputs, one per channel |
| irq | output | 1 | Interrupt request |
| stop_in | input | 1 | Hold the count while high |

## Verification
The assertions assume that rd_en and wr_en are never high in the same cycle. They also assume that cap_pin and stop_in are already synchronous to clk and that the capture pins are low while reset is applied, so that no edge appears at reset release. The stimulus meets these assumptions by changing every input only on falling clock edges and by issuing one register access per cycle. The bench predicts the count from its own tally of clock edges outside stop. It then times capture edges and compare targets against that prediction.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int NCH    = 2;
  localparam int FLAG_W = 1 + 2 * NCH;   // overflow, captures, compares
  localparam int CA_W   = FLAG_W + NCH;  // enables + edge selects
  localparam int CB_W   = 2 * NCH;       // output enables + levels
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL_A  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_B  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALT_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ALT_LO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP0_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP0_HI = 4'd11;

  localparam int FL_OVF = 0;
  localparam int FL_CAP = 1;
  localparam int FL_CMP = 1 + NCH;
endpackage

// File: rtl/ctm_prescale_counter.sv
module ctm_prescale_counter #(
  parameter int PRE_DIV = 4,
  parameter int CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_in,
  output logic             tick,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PRE_W-1:0] pre_q;

  assign tick    = !stop_in && (pre_q == PRE_LAST);
  assign cnt_nxt = cnt_q + CNT_ONE;
  assign wrap    = tick && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= RST_VAL;
    end else if (!stop_in) begin
      pre_q <= tick ? '0 : pre_q + PRE_ONE;
      if (tick) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ctm_capture.sv
module ctm_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rise_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] cap_q
);
  logic pin_prev;

  assign hit = rise_sel ? (pin && !pin_prev) : (!pin && pin_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= 1'b0;
      cap_q    <= '0;
    end else begin
      pin_prev <= pin;
      if (hit) cap_q <= cnt;
    end
  end
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              oe,
  input  logic              lvl,
  output logic              hit,
  output logic              pin_q,
  output logic [CNT_W-1:0]  cmp_q
);
  logic inhibit_q;

  assign hit = tick && !inhibit_q && (cnt_nxt == cmp_q);

  // compare value is deliberately left out of reset
  always_ff @(posedge clk) begin
    if (wr_hi) cmp_q[CNT_W-1:BYTE_W] <= wr_byte[CNT_W-BYTE_W-1:0];
    if (wr_lo) cmp_q[BYTE_W-1:0]     <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit_q <= 1'b1;
      pin_q     <= 1'b0;
    end else begin
      if (wr_hi)      inhibit_q <= 1'b1;
      else if (wr_lo) inhibit_q <= 1'b0;
      if (hit && oe) pin_q <= lvl;
    end
  end
endmodule

// File: rtl/ctm_timer.sv
module ctm_timer
  import ctm_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter logic [CNT_W-1:0] CNT_RST = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [NCH-1:0]    cap_pin,
  output logic [NCH-1:0]    cmp_pin,
  output logic              irq,
  input  logic              stop_in
);
  logic                        tick, wrap;
  logic [CNT_W-1:0]            cnt_q, cnt_nxt;
  logic [CA_W-1:0]             ctrl_a;
  logic [CB_W-1:0]             ctrl_b;
  logic [FLAG_W-1:0]           flags, arm, set_v, clr_v;
  logic [NCH-1:0][CNT_W-1:0]   cap_val, cmp_val;
  logic [NCH-1:0]              cap_hit, cmp_hit;
  logic [BYTE_W-1:0]           lo_buf;
  logic                        lo_held;
  logic                        st_rd, hi_rd, lo_rd;

  assign st_rd = rd_en && (addr == A_STATUS);
  assign hi_rd = rd_en && (addr == A_CNT_HI || addr == A_ALT_HI);
  assign lo_rd = rd_en && (addr == A_CNT_LO || addr == A_ALT_LO);

  ctm_prescale_counter #(.PRE_DIV(PRE_DIV), .CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stop_in(stop_in), .tick(tick), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .cnt_q(cnt_q)
  );

  assign set_v[FL_OVF] = wrap;
  assign clr_v[FL_OVF] = arm[FL_OVF] && rd_en && (addr == A_CNT_LO);

  for (genvar i = 0; i < NCH; i++) begin : g_cap
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CAP0_HI + 2 * i + 1);
    ctm_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[i]), .rise_sel(ctrl_a[FLAG_W+i]),
      .cnt(cnt_q), .hit(cap_hit[i]), .cap_q(cap_val[i])
    );
    assign set_v[FL_CAP+i] = cap_hit[i];
    assign clr_v[FL_CAP+i] = arm[FL_CAP+i] && rd_en && (addr == LO_A);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_CMP0_HI + 2 * i);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CMP0_HI + 2 * i + 1);
    ctm_compare #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr_hi(wr_en && addr == HI_A), .wr_lo(wr_en && addr == LO_A),
      .wr_byte(wr_data), .tick(tick), .cnt_nxt(cnt_nxt),
      .oe(ctrl_b[i]), .lvl(ctrl_b[NCH+i]),
      .hit(cmp_hit[i]), .pin_q(cmp_pin[i]), .cmp_q(cmp_val[i])
    );
    assign set_v[FL_CMP+i] = cmp_hit[i];
    assign clr_v[FL_CMP+i] = arm[FL_CMP+i] && wr_en && (addr == LO_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a  <= '0;
      ctrl_b  <= '0;
      flags   <= '0;
      arm     <= '0;
      lo_buf  <= '0;
      lo_held <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL_A) ctrl_a <= wr_data[CA_W-1:0];
      if (wr_en && addr == A_CTRL_B) ctrl_b <= wr_data[CB_W-1:0];
      flags <= (flags & ~clr_v) | set_v;
      arm   <= (arm | (st_rd ? flags : '0)) & ~clr_v;
      if (hi_rd && !lo_held) begin
        lo_buf  <= cnt_q[BYTE_W-1:0];
        lo_held <= 1'b1;
      end else if (lo_rd) begin
        lo_held <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL_A:           rd_data = BYTE_W'(ctrl_a);
        A_CTRL_B:           rd_data = BYTE_W'(ctrl_b);
        A_STATUS:           rd_data = BYTE_W'(flags);
        A_CNT_HI, A_ALT_HI: rd_data = cnt_q[CNT_W-1:BYTE_W];
        A_CNT_LO, A_ALT_LO: rd_data = lo_held ? lo_buf : cnt_q[BYTE_W-1:0];
        default:            rd_data = '0;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(A_CAP0_HI + 2 * i))     rd_data = cap_val[i][CNT_W-1:BYTE_W];
        if (addr == ADDR_W'(A_CAP0_HI + 2 * i + 1)) rd_data = cap_val[i][BYTE_W-1:0];
        if (addr == ADDR_W'(A_CMP0_HI + 2 * i))     rd_data = cmp_val[i][CNT_W-1:BYTE_W];
        if (addr == ADDR_W'(A_CMP0_HI + 2 * i + 1)) rd_data = cmp_val[i][BYTE_W-1:0];
      end
    end
  end

  assign irq = |(flags & ctrl_a[FLAG_W-1:0]);
endmodule

// File: rtl/ctm_timer_chk.sv
module ctm_timer_chk
  import ctm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stop_in,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              irq,
  input logic [NCH-1:0]    cmp_pin,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] arm,
  input logic [CB_W-1:0]   ctrl_b,
  input logic [BYTE_W-1:0] lo_buf,
  input logic              lo_held
);
  // R2: a held count does not move
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stop_in |=> $stable(cnt_q));

  // R2: the count only ever steps by one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  // R3: a held low byte stays put until a low-byte read
  a_r3_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_held && !(rd_en && (addr == A_CNT_LO || addr == A_ALT_LO))) |=> $stable(lo_buf));

  // R7: no flag drops unless it was armed by a status read
  a_r7_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags) & ~$past(arm)) == '0));

  // R8: second count view never clears overflow
  a_r8_alt_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_ALT_HI || addr == A_ALT_LO) && flags[FL_OVF]) |=> flags[FL_OVF]);

  // R10: a request needs a pending flag
  a_r10_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    // R5: a compare pin moves only with its output enabled
    a_r5_pin_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmp_pin[i]) |-> $past(ctrl_b[i]));
  end
endmodule

bind ctm_timer ctm_timer_chk u_chk (.*);

// File: tb/ctm_timer_bench.sv
module ctm_timer_bench;
  localparam logic [3:0] AD_CA = 4'd0, AD_CB = 4'd1, AD_ST = 4'd2;
  localparam logic [3:0] AD_CH = 4'd3, AD_CL = 4'd4, AD_AH = 4'd5, AD_AL = 4'd6;
  localparam logic [3:0] AD_P0H = 4'd7, AD_P0L = 4'd8, AD_P1H = 4'd9, AD_P1L = 4'd10;
  localparam logic [3:0] AD_M0H = 4'd11, AD_M0L = 4'd12, AD_M1H = 4'd13, AD_M1L = 4'd14;

  // {is_read, addr, write data, expected read}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, AD_ST, 8'h00, 8'h00},
    {1'b0, AD_CA, 8'hFF, 8'h00},
    {1'b1, AD_CA, 8'h00, 8'h7F},
    {1'b0, AD_CA, 8'h20, 8'h00},
    {1'b1, AD_CA, 8'h00, 8'h20},
    {1'b0, AD_CB, 8'hFF, 8'h00},
    {1'b1, AD_CB, 8'h00, 8'h0F},
    {1'b0, AD_CB, 8'h0D, 8'h00},
    {1'b1, AD_CB, 8'h00, 8'h0D}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr_en, rd_en, stop_in, irq;
  logic [3:0] addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] cap_pin, cmp_pin;

  int n_chk = 0, n_bad = 0;
  int unsigned act = 0;

  ctm_timer u_ctm_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .cap_pin(cap_pin), .cmp_pin(cmp_pin),
    .irq(irq), .stop_in(stop_in)
  );

  // model: clock edges counted outside reset and stop
  always @(posedge clk) begin
    if (!rst_n) act <= 0;
    else if (!stop_in) act <= act + 1;
  end

  function automatic logic [15:0] mdl();
    return 16'hFFFC + 16'(act / 4);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic [15:0] m);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data; m = mdl();
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic rd_pair(input logic [3:0] hi, output logic [15:0] got, output logic [15:0] exp);
    logic [7:0] dh, dl;
    logic [15:0] mx;
    rd(hi, dh, exp);
    rd(hi + 4'd1, dl, mx);
    got = {dh, dl};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  d, d2;
    logic [15:0] m, m1, g, e, g2, t;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; stop_in = 1'b0;
    addr = '0; wr_data = '0; cap_pin = '0;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pins", {14'd0, cmp_pin}, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
    rd(AD_CH, d, m);
    rd(AD_CL, d2, m1);
    check("R1 count", {d, d2}, 16'hFFFC);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] vd;
      logic [15:0] vm;
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], vd, vm);
        check("R11 readback", {8'h00, vd}, {8'h00, VEC[i][7:0]});
      end else begin
        wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R6 overflow
    while (act < 24) @(negedge clk);
    check("R10 irq off", {15'd0, irq}, 16'h0);
    rd(AD_CL, d, m);
    rd(AD_ST, d, m);
    check("R6 ovf / R7 unarmed access", {8'h00, d}, 16'h0001);
    rd(AD_AH, d, m);
    check("R8 alt value", {8'h00, d}, {8'h00, m[15:8]});
    rd(AD_AL, d, m);
    rd(AD_ST, d, m);
    check("R8 alt keeps ovf", {8'h00, d}, 16'h0001);
    wr(AD_CA, 8'h21);
    check("R10 irq on", {15'd0, irq}, 16'h1);
    rd(AD_CL, d, m);
    rd(AD_ST, d, m);
    check("R7 ovf cleared", {8'h00, d}, 16'h0000);
    check("R10 irq drops", {15'd0, irq}, 16'h0);

    // R3 coherent read
    rd(AD_CH, d, m1);
    idle(12);
    rd(AD_CH, d, m);
    rd(AD_CL, d2, m);
    check("R3 buffered low", {8'h00, d2}, {8'h00, m1[7:0]});

    // R2 rate and stop
    idle(7);
    rd_pair(AD_CH, g, e);
    check("R2 count", g, e);
    @(negedge clk) stop_in = 1'b1;
    rd_pair(AD_CH, g, e);
    check("R2 count in stop", g, e);
    idle(20);
    rd_pair(AD_AH, g2, e);
    check("R2 frozen", g2, g);
    stop_in = 1'b0;
    idle(9);
    rd_pair(AD_CH, g, e);
    check("R2 resumed", g, e);

    // R4 capture channel 0, rising
    @(negedge clk);
    cap_pin[0] = 1'b1;
    t = mdl();
    idle(2);
    rd_pair(AD_P0H, g, e);
    check("R4 cap0 value", g, t);
    rd(AD_ST, d, m);
    check("R4 cap0 flag", {8'h00, d & 8'h06}, 16'h0002);
    idle(8);
    @(negedge clk) cap_pin[0] = 1'b0;
    idle(8);
    rd_pair(AD_P0H, g, e);
    check("R4 falling ignored", g, t);
    rd(AD_ST, d, m);
    check("R7 cap0 cleared", {8'h00, d & 8'h06}, 16'h0000);

    // R4 capture channel 1, falling
    @(negedge clk) cap_pin[1] = 1'b1;
    idle(8);
    rd(AD_ST, d, m);
    check("R4 rising ignored", {8'h00, d & 8'h04}, 16'h0000);
    @(negedge clk);
    cap_pin[1] = 1'b0;
    t = mdl();
    idle(2);
    rd_pair(AD_P1H, g, e);
    check("R4 cap1 value", g, t);
    rd(AD_ST, d, m);
    check("R4 cap1 flag", {8'h00, d & 8'h04}, 16'h0004);

    // R5 compare channel 0 with output
    t = mdl() + 16'd5;
    wr(AD_M0H, t[15:8]);
    wr(AD_M0L, t[7:0]);
    while (mdl() != t - 16'd1) @(negedge clk);
    check("R5 pin before match", {15'd0, cmp_pin[0]}, 16'h0);
    while (mdl() != t) @(negedge clk);
    check("R5 pin at match", {15'd0, cmp_pin[0]}, 16'h1);
    rd(AD_ST, d, m);
    check("R5 cmp0 flag", {8'h00, d & 8'h08}, 16'h0008);
    wr(AD_M0L, t[7:0]);
    rd(AD_ST, d, m);
    check("R7 cmp0 cleared", {8'h00, d & 8'h08}, 16'h0000);

    // R9 half-written compare must not match
    t = mdl() + 16'd6;
    wr(AD_M1H, t[15:8] ^ 8'h80);
    wr(AD_M1L, t[7:0]);
    wr(AD_M1H, t[15:8]);
    while (mdl() != t + 16'd2) @(negedge clk);
    rd(AD_ST, d, m);
    check("R9 inhibited", {8'h00, d & 8'h10}, 16'h0000);

    // R5 compare channel 1 without output
    t = mdl() + 16'd5;
    wr(AD_M1H, t[15:8]);
    wr(AD_M1L, t[7:0]);
    while (mdl() != t) @(negedge clk);
    check("R5 pin kept, oe clear", {15'd0, cmp_pin[1]}, 16'h0);
    check("R10 no enable", {15'd0, irq}, 16'h0);
    rd(AD_ST, d, m);
    check("R5 cmp1 flag", {8'h00, d & 8'h10}, 16'h0010);
    wr(AD_CA, 8'h31);
    check("R10 cmp1 enable", {15'd0, irq}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule